// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses for one SDRAM read or write burst. A start pulse carries a 9-bit start column, a read/write select, a burst length code, a burst type and a CAS latency choice. From the next cycle on, the block presents one column per cycle. The low column bits advance either by counting upward or by XOR with the step number, and they always stay inside the aligned window that the burst length defines. A full-page burst walks every column of the row in upward order and repeats until it is told to stop. A burst-stop input ends column generation in the cycle where it is raised.

For reads, the block runs a valid pipeline that marks the cycle in which the memory returns each beat: two or three cycles after that beat's column, depending on the latched CAS latency. Data already in flight is still marked after a burst-stop. The per-byte mask bits act differently for the two directions. On a write they gate that byte's write enable in the same cycle. On a read they turn off that byte's output enable two cycles later. A one-cycle done flag follows the final column or the stop.

Top module: `sbs_burst_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `col_vld_o`, `rd_vld_o`, `rd_oe_o`, `wr_en_o` and `done_o` are all 0.
- R2: `start_i` high in cycle c while the block is idle gives `col_vld_o` = 1 in cycle c+1, with `col_o` equal to the start column. `start_i` is ignored while a burst is active.
- R3: `len_code_i` selects the burst length as 0→1, 1→2, 2→4, 3→8, and any code with bit 2 set selects full page. A burst of length L with no stop shows `col_vld_o` in cycles c+1..c+L and raises `done_o` for exactly cycle c+L+1.
- R4: With `ilv_i` = 0 (sequential), step k gives the aligned base plus ((start offset + k) mod L), where the offset is the start column mod L.
- R5: With `ilv_i` = 1 (interleaved) and a length of 1 to 8, step k gives the aligned base plus (start offset XOR k).
- R6: A full-page burst ignores `ilv_i`. Its column rises by 1 every cycle, wraps from 511 to 0, and never ends without a stop.
- R7: `stop_i` high in a cycle while a burst is active: that cycle carries no column (`col_vld_o` = 0, no write enable), the burst ends, and `done_o` is 1 in the next cycle.
- R8: For a read, a column issued in cycle t gives `rd_vld_o` = 1 in cycle t+2 when `cl3_i` was 0 at start and in cycle t+3 when it was 1. `rd_vld_o` is 0 in all other cycles.
- R9: In a read-valid cycle u, output-enable bit b is the inverse of `dqm_i[b]` as it was in cycle u−2. Output enables are 0 outside read-valid cycles.
- R10: In a write burst, `wr_en_o[b]` = `col_vld_o` AND NOT `dqm_i[b]` in the same cycle. A write burst never raises `rd_vld_o`.
- R11: Read beats issued before a `stop_i` still produce `rd_vld_o` at their normal latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a new burst |
| col_i | input | 9 | Start column |
| wr_i | input | 1 | 1 = write burst, 0 = read burst |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| cl3_i | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| dqm_i | input | 8 | Per-byte mask |
| stop_i | input | 1 | Burst-stop |
| col_o | output | 9 | Column for the current beat |
| col_vld_o | output | 1 | A column is issued this cycle |
| rd_vld_o | output | 1 | Read data arrives this cycle |
| rd_oe_o | output | 8 | Per-byte read output enable |
| wr_en_o | output | 8 | Per-byte write enable |
| done_o | output | 1 | One-cycle pulse after the burst ends |

## Verification
The assertions check every cycle for the following:
- the first column equals the captured start column;
- full-page columns rise by one with wrap;
- a stop leaves no column in the following cycle;
- done never coincides with an issued column;
- masked bytes are never write-enabled;
- output enables appear only in read-valid cycles;
- read-valid follows each issued read beat at the latched latency.

Only the bench's scenarios can show the following:
- the exact wrap order for each length and type;
- where a burst ends;
- the two-cycle read-mask alignment against real mask patterns;
- the rejection of a start during a busy burst;
- beats still in the pipeline being delivered after a stop.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int SBS_COL_W = 9;
  typedef logic [SBS_COL_W-1:0] col_t;

  // Window mask for a burst length code; bit 2 set means a full row.
  function automatic col_t len_mask(input logic [2:0] code);
    col_t m;
    if (code[2]) m = '1;
    else         m = col_t'((1 << code[1:0]) - 1);
    return m;
  endfunction

  // Column of step k: upper bits kept, low bits advanced inside the window.
  function automatic col_t step_col(input col_t base, input col_t k,
                                    input col_t m, input logic ilv);
    col_t low;
    low = ilv ? (base ^ k) : (base + k);
    return (base & ~m) | (low & m);
  endfunction
endpackage

// File: rtl/sbs_addr_gen.sv
module sbs_addr_gen
  import sbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  col_t       col_i,
  input  logic [2:0] len_code_i,
  input  logic       ilv_i,
  input  logic       stop_i,
  output logic       accept_o,
  output logic       busy_o,
  output logic       issue_o,
  output logic       fp_o,
  output col_t       col_o,
  output logic       done_o
);
  logic act_q, ilv_q, fp_q, done_q;
  col_t k_q, base_q, mask_q;
  logic end_now;

  assign accept_o = start_i & ~act_q;
  assign issue_o  = act_q & ~stop_i;
  assign end_now  = act_q & (stop_i | (~fp_q & (k_q == mask_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ilv_q  <= 1'b0;
      fp_q   <= 1'b0;
      done_q <= 1'b0;
      k_q    <= '0;
      base_q <= '0;
      mask_q <= '0;
    end else begin
      done_q <= end_now;
      if (accept_o) begin
        act_q  <= 1'b1;
        k_q    <= '0;
        base_q <= col_i;
        mask_q <= len_mask(len_code_i);
        fp_q   <= len_code_i[2];
        ilv_q  <= ilv_i & ~len_code_i[2];
      end else if (end_now) begin
        act_q <= 1'b0;
      end else if (act_q) begin
        k_q <= k_q + 1'b1;
      end
    end
  end

  assign busy_o = act_q;
  assign fp_o   = fp_q;
  assign col_o  = step_col(base_q, k_q, mask_q, ilv_q);
  assign done_o = done_q;
endmodule

// File: rtl/sbs_rd_pipe.sv
module sbs_rd_pipe #(
  parameter int BYTES    = 8,
  parameter int MIN_CL   = 2,
  parameter int MAX_CL   = 3,
  parameter int MASK_LAT = 2,
  localparam int CLW     = $clog2(MAX_CL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             cl3_i,
  input  logic             issue_rd_i,
  input  logic [BYTES-1:0] dqm_i,
  output logic [CLW-1:0]   cl_o,
  output logic             rd_vld_o,
  output logic [BYTES-1:0] rd_oe_o
);
  logic [MAX_CL:1]  pipe_q;
  logic [CLW-1:0]   cl_q;
  logic [BYTES-1:0] msk_q [MASK_LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_q <= '0;
      cl_q   <= CLW'(MIN_CL);
    end else begin
      pipe_q[1] <= issue_rd_i;
      for (int i = 2; i <= MAX_CL; i++) pipe_q[i] <= pipe_q[i-1];
      if (load_i) cl_q <= cl3_i ? CLW'(MAX_CL) : CLW'(MIN_CL);
    end
  end

  for (genvar s = 0; s < MASK_LAT; s++) begin : g_msk
    always_ff @(posedge clk) begin
      if (!rst_n)     msk_q[s] <= '0;
      else if (s == 0) msk_q[s] <= dqm_i;
      else            msk_q[s] <= msk_q[(s == 0) ? 0 : s-1];
    end
  end

  assign cl_o     = cl_q;
  assign rd_vld_o = pipe_q[cl_q];
  assign rd_oe_o  = {BYTES{rd_vld_o}} & ~msk_q[MASK_LAT-1];
endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
  import sbs_pkg::*;
#(
  parameter int COL_W  = SBS_COL_W,
  parameter int BYTES  = 8,
  parameter int MIN_CL = 2,
  parameter int MAX_CL = 3,
  localparam int CLW   = $clog2(MAX_CL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             wr_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             cl3_i,
  input  logic [BYTES-1:0] dqm_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_vld_o,
  output logic             rd_vld_o,
  output logic [BYTES-1:0] rd_oe_o,
  output logic [BYTES-1:0] wr_en_o,
  output logic             done_o
);
  // Named events for the checker
  logic           accept, busy, issue, fp_mode, issue_rd;
  logic           wr_q;
  logic [CLW-1:0] rd_cl;

  sbs_addr_gen u_addr (
    .clk, .rst_n, .start_i, .col_i, .len_code_i, .ilv_i, .stop_i,
    .accept_o(accept), .busy_o(busy), .issue_o(issue), .fp_o(fp_mode),
    .col_o, .done_o
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      wr_q <= 1'b0;
    else if (accept) wr_q <= wr_i;
  end

  assign issue_rd  = issue & ~wr_q;
  assign col_vld_o = issue;
  assign wr_en_o   = {BYTES{issue & wr_q}} & ~dqm_i;

  sbs_rd_pipe #(.BYTES(BYTES), .MIN_CL(MIN_CL), .MAX_CL(MAX_CL), .MASK_LAT(2)) u_rd (
    .clk, .rst_n, .load_i(accept), .cl3_i, .issue_rd_i(issue_rd), .dqm_i,
    .cl_o(rd_cl), .rd_vld_o, .rd_oe_o
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int COL_W = 9,
  parameter int BYTES = 8,
  parameter int CLW   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [COL_W-1:0] col_i,
  input logic             stop_i,
  input logic [BYTES-1:0] dqm_i,
  input logic [COL_W-1:0] col_o,
  input logic             col_vld_o,
  input logic             rd_vld_o,
  input logic [BYTES-1:0] rd_oe_o,
  input logic [BYTES-1:0] wr_en_o,
  input logic             done_o,
  input logic             accept,
  input logic             busy,
  input logic             fp_mode,
  input logic             issue_rd,
  input logic [CLW-1:0]   rd_cl
);
  logic [COL_W-1:0] col_inc_q;
  logic [COL_W-1:0] col_cap_q;
  always_ff @(posedge clk) begin
    col_inc_q <= col_o + 1'b1;
    col_cap_q <= col_i;
  end

  AST_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept) |-> (col_vld_o -> col_o == col_cap_q)); // R2
  AST_DONE_NO_COL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !col_vld_o); // R3
  AST_FULLPAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_mode && col_vld_o && $past(col_vld_o) && !$past(accept)) |-> col_o == col_inc_q); // R6
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && busy) |=> !col_vld_o); // R7
  AST_RD_CL2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cl == CLW'(2) && $past(rd_cl, 2) == rd_cl && $past(issue_rd, 2)) |-> rd_vld_o); // R8
  AST_RD_CL3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cl == CLW'(3) && $past(rd_cl, 3) == rd_cl && $past(issue_rd, 3)) |-> rd_vld_o); // R8
  AST_OE_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_oe_o) |-> rd_vld_o); // R9
  AST_WR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(wr_en_o & dqm_i))); // R10
endmodule

bind sbs_burst_seq sbs_checker #(.COL_W(COL_W), .BYTES(BYTES), .CLW(CLW)) u_chk (
  .clk, .rst_n, .col_i, .stop_i, .dqm_i, .col_o, .col_vld_o, .rd_vld_o,
  .rd_oe_o, .wr_en_o, .done_o, .accept, .busy, .fp_mode, .issue_rd, .rd_cl
);

// File: tb/sbs_burst_seq_tb.sv
module sbs_burst_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, wr_i = 0, ilv_i = 0, cl3_i = 0, stop_i = 0;
  logic [8:0] col_i = '0;
  logic [2:0] len_code_i = '0;
  logic [7:0] dqm_i = '0;
  logic [8:0] col_o;
  logic col_vld_o, rd_vld_o, done_o;
  logic [7:0] rd_oe_o, wr_en_o;

  always #5 clk = ~clk;

  sbs_burst_seq u_dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // Reference model state
  bit m_act = 0, m_wr = 0, m_ilv = 0, m_fp = 0, m_done = 0;
  int m_k = 0, m_col = 0, m_len = 1, m_cl = 2;
  bit rdv[int];
  logic [7:0] dqmh[int];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d act=%0h exp=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input bit st, input logic [8:0] c, input bit w,
                      input logic [2:0] bl, input bit bt, input bit c3, input bit sp);
    bit e_vld, e_rd, e_end;
    int base, off, e_col;
    logic [7:0] e_oe, e_wr, pat;
    @(negedge clk);
    pat = 8'((cyc * 29) ^ (cyc >> 2));
    if (cyc % 5 == 0) pat = 8'h00;
    start_i = st; col_i = c; wr_i = w; len_code_i = bl; ilv_i = bt;
    cl3_i = c3; stop_i = sp; dqm_i = pat;
    #1;
    e_vld = m_act && !sp;
    base = m_col - (m_col % m_len);
    off = m_col % m_len;
    e_col = m_ilv ? base + (off ^ m_k) : base + ((off + m_k) % m_len);
    e_rd = rdv.exists(cyc);
    e_oe = e_rd ? ~dqmh[cyc-2] : 8'h00;
    e_wr = (e_vld && m_wr) ? ~pat : 8'h00;
    chk("R2 R7 col_vld", col_vld_o, e_vld);
    if (e_vld) chk(m_fp ? "R6 col" : (m_k == 0 ? "R2 col" : (m_ilv ? "R5 col" : "R4 col")),
                   col_o, e_col);
    chk("R3 done", done_o, m_done);
    chk("R8 R11 rd_vld", rd_vld_o, e_rd);
    chk("R9 rd_oe", rd_oe_o, e_oe);
    chk("R10 wr_en", wr_en_o, e_wr);
    // Model the coming clock edge
    dqmh[cyc] = pat;
    if (e_vld && !m_wr) rdv[cyc + m_cl] = 1;
    e_end = m_act && (sp || (!m_fp && m_k == m_len - 1));
    m_done = e_end;
    if (!m_act && st) begin
      m_act = 1; m_k = 0; m_col = c; m_wr = w; m_cl = c3 ? 3 : 2;
      m_fp = bl[2]; m_len = bl[2] ? 512 : (1 << bl[1:0]); m_ilv = bt && !bl[2];
    end else if (e_end) m_act = 0;
    else if (m_act) m_k = (m_k + 1) % 512;
    cyc++;
  endtask

  task automatic burst(input logic [8:0] c, input bit w, input logic [2:0] bl,
                       input bit bt, input bit c3, input int n, input int stop_at,
                       input int restart_at);
    step(1, c, w, bl, bt, c3, 0);
    for (int i = 1; i <= n; i++)
      step(i == restart_at, c ^ 9'h0F0, ~w, 3'd0, ~bt, ~c3, i == stop_at);
    for (int i = 0; i < 6; i++) step(0, 9'h000, 0, 3'd0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle during reset
    chk("R1 reset col_vld", col_vld_o, 0);
    chk("R1 reset rd_vld", rd_vld_o, 0);
    chk("R1 reset rd_oe", rd_oe_o, 0);
    chk("R1 reset wr_en", wr_en_o, 0);
    chk("R1 reset done", done_o, 0);
    rst_n = 1'b1;
    step(0, 9'h000, 0, 3'd0, 0, 0, 0);
    burst(9'h1FD, 0, 3'd0, 0, 0, 3, -1, -1);   // R3 length 1
    burst(9'h1FD, 0, 3'd1, 0, 1, 4, -1, -1);   // R4 length 2 wrap
    burst(9'h0A6, 0, 3'd2, 0, 0, 6, -1, 2);    // R2 restart ignored
    burst(9'h1FD, 0, 3'd3, 0, 1, 10, -1, -1);  // R4 length 8 wrap, R8 CL3
    burst(9'h05B, 0, 3'd2, 1, 1, 6, -1, -1);   // R5 interleave 4
    burst(9'h0D5, 0, 3'd3, 1, 0, 10, -1, -1);  // R5 interleave 8
    burst(9'h013, 1, 3'd3, 0, 0, 8, 5, -1);    // R10 write, R7 stop
    burst(9'h1FC, 0, 3'd7, 1, 1, 10, 8, -1);   // R6 ilv ignored, R11
    burst(9'h1FE, 1, 3'd4, 0, 0, 600, 600, 100); // R6 wrap 511->0
    burst(9'h044, 0, 3'd5, 0, 0, 3, 1, -1);    // R7 R11 early stop CL2
    burst(9'h100, 0, 3'd3, 1, 0, 9, -1, -1);   // R3 done after 8
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule